// File: doc/BRIEF.md
# Processor Stop-Clock Power Controller

This block sequences the power states of a processor core. It runs on an always-on reference clock and moves between five states: running, grant (clock-stop acknowledged, clock still running), stopped (input clock halted), halted (auto power-down after a halt instruction) and snoop (a one-cycle wake-up from the stopped state that invalidates the cache). It issues one-cycle strobes that ask the bus unit to run a stop-grant cycle or a halt cycle. It also produces a cache-invalidate pulse and the core clock-gate enable.

While in grant with the clock running, the block answers a bus hold request with a hold acknowledge and an output-float enable. While in grant, stopped or snoop, the core's output bus is frozen at the value it had just before grant was entered. Leaving the stopped state requires the clock-running indication to be high for a parameterised number of consecutive reference cycles. Reset sources override everything.

Top module: `pwr_stopclk_top`

## Requirements
- R1: `stateOut` encodes running=0, grant=1, stopped=2, halted=3, snoop=4. While `rstN` is low the state is running, all strobes and `holdAck`/`floatEn` are low, and `clkGateEn` is high.
- R2: In running, a high `stopReq` moves the state to grant. `stopGrantCycle` is high for exactly the first cycle of grant. If `haltIn` is high in the same cycle, `stopReq` wins.
- R3: In running with `stopReq` low, a high `haltIn` moves the state to halted. `haltCycle` is high for exactly the first cycle of halted.
- R4: In grant with `clkRunning` high, a low `stopReq` leaves grant. The state goes to running if grant was last entered from running. It goes to halted, with a one-cycle `haltCycle`, if grant was last entered from halted.
- R5: In halted, a high `stopReq` moves to grant with a one-cycle `stopGrantCycle`. Otherwise a high `intrIn`, `nmiIn` or `smiIn` moves to running. `stopReq` wins over the interrupts.
- R6: In grant, a low `clkRunning` moves to stopped and takes priority over `stopReq`. `clkGateEn` is low in stopped and high in every other state.
- R7: In stopped, the state returns to grant on the edge that completes `START_LAT` consecutive cycles of `clkRunning` high. A low cycle restarts the count.
- R8: In stopped, a high `snoopStrobe` moves to snoop for exactly one cycle, then back to stopped. Throughout the snoop cycle, `invalidatePulse` and `clkGateEn` are high. `snoopStrobe` has no effect in any other state.
- R9: `holdAck` and `floatEn` are high in a cycle exactly when the previous cycle had state grant, `clkRunning` high and `holdReq` high.
- R10: `pinOut` equals `coreOut` in running and halted. In grant, stopped and snoop it holds the `coreOut` value sampled on the edge that entered grant, and it keeps that value across a hold sequence.
- R11: A high `cpuReset` or `softReset` forces running on the next edge from any state, ahead of every other event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| stopReq | input | 1 | Clock-stop request, level |
| haltIn | input | 1 | Core has executed a halt |
| intrIn | input | 1 | Maskable interrupt |
| nmiIn | input | 1 | Non-maskable interrupt |
| smiIn | input | 1 | System-management interrupt |
| cpuReset | input | 1 | Hard reset of the core |
| softReset | input | 1 | Soft reset of the core |
| snoopStrobe | input | 1 | External snoop/invalidate request |
| clkRunning | input | 1 | Core input clock is toggling |
| holdReq | input | 1 | Bus hold request |
| coreOut | input | OUT_W | Output levels driven by the core |
| stateOut | output | 3 | Current power state |
| stopGrantCycle | output | 1 | One-cycle request for a stop-grant bus cycle |
| haltCycle | output | 1 | One-cycle request for a halt bus cycle |
| invalidatePulse | output | 1 | Cache invalidate, high during snoop |
| holdAck | output | 1 | Hold acknowledge |
| floatEn | output | 1 | Float the floatable outputs |
| clkGateEn | output | 1 | Core clock-gate enable |
| pinOut | output | OUT_W | Output levels presented to the pins |

## Verification
A wrong state register shows on `stateOut` and `clkGateEn` on the very next edge. A lost record of where grant came from stays hidden until `stopReq` drops; the state then goes to running instead of halted, and no `haltCycle` appears. A miscounting restart counter shows up as the exit from stopped moving by one or more cycles, so the bench pins that exit to the exact edge. A faulty freeze register shows up as `pinOut` following `coreOut` during grant.

// File: rtl/pwr_stopclk_pkg.sv
package pwr_stopclk_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_GRANT   = 3'd1,
    ST_STOPPED = 3'd2,
    ST_HALTED  = 3'd3,
    ST_SNOOP   = 3'd4
  } pwrStateT;

  typedef struct packed {
    logic inGrant;
    logic inStopped;
    logic freeze;
  } ctrlStrobeT;
endpackage

// File: rtl/pwr_stopclk_ctrl.sv
module pwr_stopclk_ctrl
  import pwr_stopclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopReq,
  input  logic       haltIn,
  input  logic       intrIn,
  input  logic       nmiIn,
  input  logic       smiIn,
  input  logic       cpuReset,
  input  logic       softReset,
  input  logic       snoopStrobe,
  input  logic       clkRunning,
  input  logic       latDone,
  output ctrlStrobeT strobes,
  output pwrStateT   state,
  output logic       stopGrantCycle,
  output logic       haltCycle,
  output logic       invalidatePulse,
  output logic       clkGateEn
);
  pwrStateT stateQ, stateNext;
  logic fromHaltQ, fromHaltNext;
  logic sgNext, htNext;
  logic wakeIrq, anyReset;

  assign wakeIrq  = intrIn | nmiIn | smiIn;
  assign anyReset = cpuReset | softReset;

  always_comb begin
    stateNext    = stateQ;
    fromHaltNext = fromHaltQ;
    sgNext       = 1'b0;
    htNext       = 1'b0;
    if (anyReset) begin
      stateNext    = ST_RUN;
      fromHaltNext = 1'b0;
    end else begin
      unique case (stateQ)
        ST_RUN: begin
          if (stopReq) begin
            stateNext    = ST_GRANT;
            fromHaltNext = 1'b0;
            sgNext       = 1'b1;
          end else if (haltIn) begin
            stateNext = ST_HALTED;
            htNext    = 1'b1;
          end
        end
        ST_HALTED: begin
          if (stopReq) begin
            stateNext    = ST_GRANT;
            fromHaltNext = 1'b1;
            sgNext       = 1'b1;
          end else if (wakeIrq) begin
            stateNext = ST_RUN;
          end
        end
        ST_GRANT: begin
          if (!clkRunning) begin
            stateNext = ST_STOPPED;
          end else if (!stopReq) begin
            if (fromHaltQ) begin
              stateNext = ST_HALTED;
              htNext    = 1'b1;
            end else begin
              stateNext = ST_RUN;
            end
            fromHaltNext = 1'b0;
          end
        end
        ST_STOPPED: begin
          if (snoopStrobe)  stateNext = ST_SNOOP;
          else if (latDone) stateNext = ST_GRANT;
        end
        ST_SNOOP: stateNext = ST_STOPPED;
        default:  stateNext = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ          <= ST_RUN;
      fromHaltQ       <= 1'b0;
      stopGrantCycle  <= 1'b0;
      haltCycle       <= 1'b0;
      invalidatePulse <= 1'b0;
    end else begin
      stateQ          <= stateNext;
      fromHaltQ       <= fromHaltNext;
      stopGrantCycle  <= sgNext;
      haltCycle       <= htNext;
      invalidatePulse <= (stateNext == ST_SNOOP);
    end
  end

  assign state             = stateQ;
  assign clkGateEn         = (stateQ != ST_STOPPED);
  assign strobes.inGrant   = (stateQ == ST_GRANT);
  assign strobes.inStopped = (stateQ == ST_STOPPED);
  assign strobes.freeze    = (stateQ == ST_GRANT) || (stateQ == ST_STOPPED) ||
                             (stateQ == ST_SNOOP);
endmodule

// File: rtl/pwr_stopclk_dp.sv
module pwr_stopclk_dp
  import pwr_stopclk_pkg::*;
#(
  parameter int OUT_W     = 8,
  parameter int START_LAT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobes,
  input  logic             clkRunning,
  input  logic             holdReq,
  input  logic [OUT_W-1:0] coreOut,
  output logic             latDone,
  output logic             holdAck,
  output logic [OUT_W-1:0] pinOut
);
  localparam int CNT_W = (START_LAT > 1) ? $clog2(START_LAT) : 1;
  localparam logic [CNT_W-1:0] LAT_LAST = CNT_W'(START_LAT - 1);

  logic [CNT_W-1:0] latCnt;
  logic [OUT_W-1:0] heldQ;

  assign latDone = strobes.inStopped && clkRunning && (latCnt == LAT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCnt <= '0;
    end else if (!strobes.inStopped || !clkRunning || latDone) begin
      latCnt <= '0;
    end else begin
      latCnt <= latCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldQ <= '0;
    end else if (!strobes.freeze) begin
      heldQ <= coreOut;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdAck <= 1'b0;
    else       holdAck <= strobes.inGrant && clkRunning && holdReq;
  end

  assign pinOut = strobes.freeze ? heldQ : coreOut;
endmodule

// File: rtl/pwr_stopclk_top.sv
module pwr_stopclk_top
  import pwr_stopclk_pkg::*;
#(
  parameter int OUT_W     = 8,
  parameter int START_LAT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stopReq,
  input  logic             haltIn,
  input  logic             intrIn,
  input  logic             nmiIn,
  input  logic             smiIn,
  input  logic             cpuReset,
  input  logic             softReset,
  input  logic             snoopStrobe,
  input  logic             clkRunning,
  input  logic             holdReq,
  input  logic [OUT_W-1:0] coreOut,
  output logic [2:0]       stateOut,
  output logic             stopGrantCycle,
  output logic             haltCycle,
  output logic             invalidatePulse,
  output logic             holdAck,
  output logic             floatEn,
  output logic             clkGateEn,
  output logic [OUT_W-1:0] pinOut
);
  ctrlStrobeT strobes;
  pwrStateT   state;
  logic       latDone;

  pwr_stopclk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .haltIn(haltIn),
    .intrIn(intrIn), .nmiIn(nmiIn), .smiIn(smiIn), .cpuReset(cpuReset),
    .softReset(softReset), .snoopStrobe(snoopStrobe), .clkRunning(clkRunning),
    .latDone(latDone), .strobes(strobes), .state(state),
    .stopGrantCycle(stopGrantCycle), .haltCycle(haltCycle),
    .invalidatePulse(invalidatePulse), .clkGateEn(clkGateEn)
  );

  pwr_stopclk_dp #(.OUT_W(OUT_W), .START_LAT(START_LAT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .clkRunning(clkRunning),
    .holdReq(holdReq), .coreOut(coreOut), .latDone(latDone),
    .holdAck(holdAck), .pinOut(pinOut)
  );

  assign stateOut = state;
  assign floatEn  = holdAck;
endmodule

// File: rtl/pwr_stopclk_chk.sv
module pwr_stopclk_chk #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             stopReq,
  input logic             clkRunning,
  input logic             holdReq,
  input logic             cpuReset,
  input logic             softReset,
  input logic [2:0]       stateOut,
  input logic             stopGrantCycle,
  input logic             haltCycle,
  input logic             invalidatePulse,
  input logic             holdAck,
  input logic             clkGateEn,
  input logic [OUT_W-1:0] pinOut
);
  // R2 / R5: stop-grant strobe only on entry to grant
  a_r2_sg_on_entry: assert property (@(posedge clk) disable iff (!rstN)
    stopGrantCycle |-> (stateOut == 3'd1) &&
                       ($past(stateOut) == 3'd0 || $past(stateOut) == 3'd3));

  // R3 / R4: halt strobe only on entry to halted
  a_r3_halt_on_entry: assert property (@(posedge clk) disable iff (!rstN)
    haltCycle |-> (stateOut == 3'd3) && ($past(stateOut) != 3'd3));

  // R8: snoop reached only from stopped and followed by stopped
  a_r8_snoop_from_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd4) |-> ($past(stateOut) == 3'd2));
  a_r8_snoop_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (invalidatePulse && !cpuReset && !softReset) |=> (stateOut == 3'd2));

  // R6: clock gated only in stopped
  a_r6_gate_low_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !clkGateEn |-> (stateOut == 3'd2));

  // R9: hold acknowledge follows a granted hold with clock running
  a_r9_hold_ack: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> ($past(stateOut) == 3'd1) && $past(holdReq) && $past(clkRunning));

  // R10: pins frozen while grant persists
  a_r10_pins_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd1 && $past(stateOut) == 3'd1) |-> $stable(pinOut));

  // R11: reset sources force running
  a_r11_reset_wins: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReset || softReset) |=> (stateOut == 3'd0));
endmodule

bind pwr_stopclk_top pwr_stopclk_chk #(.OUT_W(OUT_W)) u_chk (.*);

// File: tb/pwr_stopclk_top_tb.sv
module pwr_stopclk_top_tb;
  localparam int OUT_W = 8;
  localparam int LAT   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 0, haltIn = 0, intrIn = 0, nmiIn = 0, smiIn = 0;
  logic cpuReset = 0, softReset = 0, snoopStrobe = 0, clkRunning = 1, holdReq = 0;
  logic [OUT_W-1:0] coreOut = 8'hA5;
  logic [2:0] stateOut;
  logic stopGrantCycle, haltCycle, invalidatePulse, holdAck, floatEn, clkGateEn;
  logic [OUT_W-1:0] pinOut;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct {
    logic [2:0]       st;
    logic             sg;
    logic             ht;
    logic             inv;
    logic             gate;
    logic             hack;
    logic [OUT_W-1:0] pins;
    string            req;
  } expT;
  expT sbq[$];

  always #2 clk = ~clk;

  pwr_stopclk_top #(.OUT_W(OUT_W), .START_LAT(LAT)) u_dut (.*);

  task automatic tick(input logic [2:0] st, input logic sg, input logic ht,
                      input logic inv, input logic gate, input logic hack,
                      input logic [OUT_W-1:0] pins, input string req);
    expT e;
    e.st = st; e.sg = sg; e.ht = ht; e.inv = inv; e.gate = gate;
    e.hack = hack; e.pins = pins; e.req = req;
    sbq.push_back(e);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (rstN && sbq.size() > 0) begin
      expT e;
      e = sbq.pop_front();
      checks++;
      if (stateOut !== e.st || stopGrantCycle !== e.sg || haltCycle !== e.ht ||
          invalidatePulse !== e.inv || clkGateEn !== e.gate || holdAck !== e.hack ||
          floatEn !== e.hack || pinOut !== e.pins) begin
        errors++;
        $display("FAIL %s: got st=%0d sg=%b ht=%b inv=%b gate=%b hack=%b flt=%b pins=%h exp st=%0d sg=%b ht=%b inv=%b gate=%b hack=%b pins=%h",
                 e.req, stateOut, stopGrantCycle, haltCycle, invalidatePulse, clkGateEn,
                 holdAck, floatEn, pinOut, e.st, e.sg, e.ht, e.inv, e.gate, e.hack, e.pins);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (stateOut !== 3'd0 || stopGrantCycle || haltCycle || invalidatePulse ||
        holdAck || floatEn || clkGateEn !== 1'b1) begin
      errors++;
      $display("FAIL R1: got st=%0d gate=%b exp st=0 gate=1", stateOut, clkGateEn);
    end
    rstN = 1'b1;
    @(negedge clk);

    tick(0, 0, 0, 0, 1, 0, 8'hA5, "R10 passthrough in running");
    snoopStrobe = 1;
    tick(0, 0, 0, 0, 1, 0, 8'hA5, "R8 snoop ignored in running");
    snoopStrobe = 0; stopReq = 1;
    tick(1, 1, 0, 0, 1, 0, 8'hA5, "R2 enter grant");
    coreOut = 8'h3C;
    tick(1, 0, 0, 0, 1, 0, 8'hA5, "R10 pins frozen in grant");
    holdReq = 1;
    tick(1, 0, 0, 0, 1, 1, 8'hA5, "R9 hold ack in grant");
    holdReq = 0;
    tick(1, 0, 0, 0, 1, 0, 8'hA5, "R9 hold released, R10 pins restored");
    clkRunning = 0; holdReq = 1;
    tick(2, 0, 0, 0, 0, 0, 8'hA5, "R6 clock stop wins over request");
    tick(2, 0, 0, 0, 0, 0, 8'hA5, "R9 no ack while stopped");
    holdReq = 0; snoopStrobe = 1;
    tick(4, 0, 0, 1, 1, 0, 8'hA5, "R8 snoop entered");
    snoopStrobe = 0;
    tick(2, 0, 0, 0, 0, 0, 8'hA5, "R8 back to stopped");
    clkRunning = 1;
    tick(2, 0, 0, 0, 0, 0, 8'hA5, "R7 count 1");
    tick(2, 0, 0, 0, 0, 0, 8'hA5, "R7 count 2");
    clkRunning = 0;
    tick(2, 0, 0, 0, 0, 0, 8'hA5, "R7 drop restarts");
    clkRunning = 1;
    tick(2, 0, 0, 0, 0, 0, 8'hA5, "R7 recount 1");
    tick(2, 0, 0, 0, 0, 0, 8'hA5, "R7 recount 2");
    tick(2, 0, 0, 0, 0, 0, 8'hA5, "R7 recount 3");
    tick(1, 0, 0, 0, 1, 0, 8'hA5, "R7 exit on last count");
    stopReq = 0;
    tick(0, 0, 0, 0, 1, 0, 8'h3C, "R4 grant from running returns to running");
    haltIn = 1;
    tick(3, 0, 1, 0, 1, 0, 8'h3C, "R3 enter halted");
    haltIn = 0; stopReq = 1; coreOut = 8'h5A;
    tick(1, 1, 0, 0, 1, 0, 8'h5A, "R5 halted to grant");
    coreOut = 8'h11;
    tick(1, 0, 0, 0, 1, 0, 8'h5A, "R10 frozen after halted");
    stopReq = 0;
    tick(3, 0, 1, 0, 1, 0, 8'h11, "R4 grant from halted returns to halted");
    intrIn = 1;
    tick(0, 0, 0, 0, 1, 0, 8'h11, "R5 intr wakes halted");
    intrIn = 0; haltIn = 1; stopReq = 1;
    tick(1, 1, 0, 0, 1, 0, 8'h11, "R2 stop request outranks halt");
    stopReq = 0; haltIn = 0;
    tick(0, 0, 0, 0, 1, 0, 8'h11, "R4 back to running");
    haltIn = 1;
    tick(3, 0, 1, 0, 1, 0, 8'h11, "R3 halted again");
    haltIn = 0; nmiIn = 1;
    tick(0, 0, 0, 0, 1, 0, 8'h11, "R5 nmi wakes halted");
    nmiIn = 0; haltIn = 1;
    tick(3, 0, 1, 0, 1, 0, 8'h11, "R3 halted for smi");
    haltIn = 0; smiIn = 1;
    tick(0, 0, 0, 0, 1, 0, 8'h11, "R5 smi wakes halted");
    smiIn = 0; haltIn = 1;
    tick(3, 0, 1, 0, 1, 0, 8'h11, "R3 halted for priority");
    haltIn = 0; stopReq = 1; intrIn = 1;
    tick(1, 1, 0, 0, 1, 0, 8'h11, "R5 stop request outranks intr");
    intrIn = 0; cpuReset = 1;
    tick(0, 0, 0, 0, 1, 0, 8'h11, "R11 hard reset from grant");
    cpuReset = 0;
    tick(1, 1, 0, 0, 1, 0, 8'h11, "R2 grant after reset");
    clkRunning = 0;
    tick(2, 0, 0, 0, 0, 0, 8'h11, "R6 stopped");
    softReset = 1; snoopStrobe = 1;
    tick(0, 0, 0, 0, 1, 0, 8'h11, "R11 soft reset from stopped beats snoop");
    softReset = 0; snoopStrobe = 0; stopReq = 0; clkRunning = 1;
    tick(0, 0, 0, 0, 1, 0, 8'h11, "R1 idle after reset");
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule